// File: doc/BRIEF.md
# Dual-Clock FIFO with Encoded Fill Flags

This block is a first-in first-out buffer for 9-bit words that sits between two unrelated clock domains. A producer writes on the rising edge of its own clock while its active-low write enable is asserted. A consumer reads on the rising edge of a separate clock while its active-low read enable is asserted. Read data is registered and holds its last word until the next accepted read.

Fill status is reported on two output pins, `flag_a` and `flag_b`. Their combined value names one of four fill bands: empty, low, middle, or high (almost full or full). Each condition is owned by one clock. The high band is computed on write-clock edges. The empty and low bands are computed on read-clock edges. Pointers cross between the domains in Gray code through two-stage synchronizers. A separate internal full bit on the write side stops overflow.

An active-low master reset, sampled synchronously by each clock, empties the buffer. It also clears the read data register to zero. Depth must be a power of two and is a parameter, default 512. The low and high thresholds are parameters too.

Top module: `dcfifo_flagged`

## Requirements
- R1: Words come out on `rd_data` in the same order they went in on `wr_data`, with all 9 bits preserved, including the all-zero and all-one words.
- R2: A write takes place on a rising `wr_clk` edge only when `wr_en_n` is 0 and the buffer is not full. A write attempted while DEPTH words are held is dropped, and the stored contents are unchanged.
- R3: A read takes place on a rising `rd_clk` edge only when `rd_en_n` is 0 and the buffer is not empty. Otherwise `rd_data` keeps its previous value. A read updates `rd_data` at the edge that accepts it.
- R4: `{flag_a, flag_b}` encodes the stored count n as follows:
  - 2'b00 when n = 0.
  - 2'b01 when 1 <= n <= LOW_LEVEL.
  - 2'b11 when LOW_LEVEL < n < HIGH_LEVEL.
  - 2'b10 when n >= HIGH_LEVEL, which includes full.
- R5: The high-band indication changes only on `wr_clk` edges. The empty and low indications change only on `rd_clk` edges. While one clock is stopped, the conditions it owns stay frozen.
- R6: After the last event from the opposite clock, the flag code reaches its correct value within five edges of the flag's own clock.
- R7: When `rst_n` is 0 at a clock edge, that clock's side returns to the empty state. After reset, `{flag_a, flag_b}` is 2'b00 and `rd_data` is all zeros.
- R8: Each cross-domain pointer changes by at most one bit per clock edge, because pointers are carried in Gray code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Master reset, active low, sampled by each clock |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 9 | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 9 | Registered word read out |
| flag_a | output | 1 | Fill code, upper bit |
| flag_b | output | 1 | Fill code, lower bit |

## Verification
The hardest case to reach from the ports is one where the two flag pins disagree with the true fill count because one clock domain has not yet seen the other side's activity. When both clocks run freely, that window lasts only a few edges. The bench therefore stops the read clock while words are written, and checks that the code stays at empty. It then stops the write clock while words are drained from the high band, and checks that the high code stays until the write clock resumes. Fill-band boundaries, overflow, reads while empty and mid-stream reset are each driven as separate directed scenarios.

// File: rtl/dcfifo_pkg.sv
// Shared definitions for the dual-clock FIFO: the fill-band code and the
// function that builds it from the per-domain status bits.
package dcfifo_pkg;

    typedef enum logic [1:0] {
        CODE_EMPTY = 2'b00,
        CODE_LOW   = 2'b01,
        CODE_MID   = 2'b11,
        CODE_HIGH  = 2'b10
    } fill_code_t;

    // High band wins, then empty, then low; anything else is the middle band.
    function automatic fill_code_t encode_fill(logic empty, logic low, logic high);
        if (high)       return CODE_HIGH;
        else if (empty) return CODE_EMPTY;
        else if (low)   return CODE_LOW;
        else            return CODE_MID;
    endfunction

endpackage

// File: rtl/dcfifo_gray_sync.sv
// Two-stage synchronizer for a Gray-coded pointer.
// Assumes the source changes at most one bit per source-clock edge.
module dcfifo_gray_sync #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);
    logic [W-1:0] stage1;

    // Purpose: resample the foreign pointer through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            gray_out <= '0;
        end else begin
            stage1   <= gray_in;
            gray_out <= stage1;
        end
    end
endmodule

// File: rtl/dcfifo_wr_ctrl.sv
// Write-side control: owns the write pointer, the internal full bit and the
// high-band flag. The read pointer it sees is synchronized and may be stale,
// so full and high are pessimistic (they may linger, never come late).
module dcfifo_wr_ctrl #(
    parameter int DEPTH      = 512,
    parameter int HIGH_LEVEL = 504
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_n,
    input  logic [$clog2(DEPTH):0]    rgray_sync,
    output logic [$clog2(DEPTH):0]    wgray,
    output logic [$clog2(DEPTH)-1:0]  waddr,
    output logic                      wr_fire,
    output logic                      high
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] FULL_N = PW'(DEPTH);
    localparam logic [PW-1:0] HIGH_N = PW'(HIGH_LEVEL);

    logic [PW-1:0] wbin, wbin_nx, rbin_s, wfill_nx, wfill;
    logic          full;

    // Purpose: next pointer, synchronized read pointer in binary, fill counts.
    always_comb begin
        wr_fire  = !wr_en_n && !full;
        wbin_nx  = wbin + {{(PW-1){1'b0}}, wr_fire};
        for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_sync >> i);
        wfill_nx = wbin_nx - rbin_s;
        wfill    = wbin - rbin_s;
    end

    assign waddr = wbin[PW-2:0];

    // Purpose: advance the pointer and register full and high from next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
            full  <= 1'b0;
            high  <= 1'b0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
            full  <= (wfill_nx == FULL_N);
            high  <= (wfill_nx >= HIGH_N);
        end
    end

    assert_fill_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wfill <= FULL_N);
    assert_full_in_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> high);
    assert_gray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcfifo_rd_ctrl.sv
// Read-side control: owns the read pointer and the empty and low flags.
// The write pointer it sees is synchronized, so empty may linger but never
// appears late. The low flag also covers the empty case.
module dcfifo_rd_ctrl #(
    parameter int DEPTH     = 512,
    parameter int LOW_LEVEL = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_en_n,
    input  logic [$clog2(DEPTH):0]    wgray_sync,
    output logic [$clog2(DEPTH):0]    rgray,
    output logic [$clog2(DEPTH)-1:0]  raddr,
    output logic                      rd_fire,
    output logic                      empty,
    output logic                      low
);
    localparam int PW = $clog2(DEPTH) + 1;
    localparam logic [PW-1:0] FULL_N = PW'(DEPTH);
    localparam logic [PW-1:0] LOW_N  = PW'(LOW_LEVEL);

    logic [PW-1:0] rbin, rbin_nx, wbin_s, rfill_nx, rfill;

    // Purpose: next pointer, synchronized write pointer in binary, fill counts.
    always_comb begin
        rd_fire  = !rd_en_n && !empty;
        rbin_nx  = rbin + {{(PW-1){1'b0}}, rd_fire};
        for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_sync >> i);
        rfill_nx = wbin_s - rbin_nx;
        rfill    = wbin_s - rbin;
    end

    assign raddr = rbin[PW-2:0];

    // Purpose: advance the pointer and register empty and low from next state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            empty <= 1'b1;
            low   <= 1'b1;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
            empty <= (rfill_nx == '0);
            low   <= (rfill_nx <= LOW_N);
        end
    end

    assert_fill_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rfill <= FULL_N);
    assert_empty_in_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> low);
    assert_gray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcfifo_store.sv
// Storage array written on the write clock. The output word is registered
// on the read clock and reset to zero. Assumes the controls never write a
// slot that is unread, nor read a slot that is unwritten.
module dcfifo_store #(
    parameter int DEPTH = 512,
    parameter int W     = 9
) (
    input  logic                     wr_clk,
    input  logic                     wr_fire,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [W-1:0]             wdata,
    input  logic                     rd_clk,
    input  logic                     rst_n,
    input  logic                     rd_fire,
    input  logic [$clog2(DEPTH)-1:0] raddr,
    output logic [W-1:0]             rdata
);
    logic [W-1:0] mem [DEPTH];

    // Purpose: store the incoming word at the write address.
    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem[waddr] <= wdata;
    end

    // Purpose: present the word at the read address when a read is accepted.
    always_ff @(posedge rd_clk) begin
        if (!rst_n)       rdata <= '0;
        else if (rd_fire) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcfifo_flagged.sv
// Dual-clock FIFO top. Joins the two control sides, the synchronizers and
// the storage, and packs the per-domain status into the two-pin fill code.
// Assumes rst_n is held low for at least two edges of each clock.
module dcfifo_flagged #(
    parameter int DEPTH      = 512,
    parameter int W          = 9,
    parameter int LOW_LEVEL  = 8,
    parameter int HIGH_LEVEL = DEPTH - 8
) (
    input  logic         wr_clk,
    input  logic         rd_clk,
    input  logic         rst_n,
    input  logic         wr_en_n,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en_n,
    output logic [W-1:0] rd_data,
    output logic         flag_a,
    output logic         flag_b
);
    import dcfifo_pkg::*;

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;
    logic [AW-1:0] waddr, raddr;
    logic          wr_fire, rd_fire, empty, low, high;
    fill_code_t    code;

    dcfifo_gray_sync #(.W(PW)) u_r2w (
        .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .gray_out(rgray_s));

    dcfifo_gray_sync #(.W(PW)) u_w2r (
        .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .gray_out(wgray_s));

    dcfifo_wr_ctrl #(.DEPTH(DEPTH), .HIGH_LEVEL(HIGH_LEVEL)) u_wr (
        .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .rgray_sync(rgray_s),
        .wgray(wgray), .waddr(waddr), .wr_fire(wr_fire), .high(high));

    dcfifo_rd_ctrl #(.DEPTH(DEPTH), .LOW_LEVEL(LOW_LEVEL)) u_rd (
        .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .wgray_sync(wgray_s),
        .rgray(rgray), .raddr(raddr), .rd_fire(rd_fire), .empty(empty),
        .low(low));

    dcfifo_store #(.DEPTH(DEPTH), .W(W)) u_mem (
        .wr_clk(wr_clk), .wr_fire(wr_fire), .waddr(waddr), .wdata(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_fire(rd_fire), .raddr(raddr),
        .rdata(rd_data));

    // Purpose: merge the write-owned high bit with the read-owned empty/low bits.
    always_comb code = encode_fill(empty, low, high);

    assign flag_a = code[1];
    assign flag_b = code[0];

    assert_hold_when_empty_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && !rd_en_n) |=> $stable(rd_data));
    assert_reset_clears_R7: assert property (@(posedge rd_clk)
        !rst_n |=> (rd_data == '0) && empty);
endmodule

// File: tb/dcfifo_flagged_tb.sv
`timescale 1ns/1ps
module dcfifo_flagged_tb;
    localparam int DEPTH = 16;
    localparam int W     = 9;
    localparam int LOW   = 4;
    localparam int HIGH  = 12;

    logic wr_clk = 0, rd_clk = 0, wr_run = 1, rd_run = 1;
    logic rst_n = 0, wr_en_n = 1, rd_en_n = 1;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic flag_a, flag_b;

    int checks = 0, errors = 0;
    logic [W-1:0] q[$];
    logic [W-1:0] last_q = '0;

    dcfifo_flagged #(.DEPTH(DEPTH), .W(W), .LOW_LEVEL(LOW), .HIGH_LEVEL(HIGH)) u_dut (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
        .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_data(rd_data),
        .flag_a(flag_a), .flag_b(flag_b));

    always #10   if (wr_run) wr_clk = ~wr_clk;   // 50 MHz write clock
    always #18.5 if (rd_run) rd_clk = ~rd_clk;   // unrelated read clock

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_code(input int n);
        if (n == 0)          return 2'b00;
        else if (n <= LOW)   return 2'b01;
        else if (n >= HIGH)  return 2'b10;
        else                 return 2'b11;
    endfunction

    task automatic chk_code(input string tag);
        chk({flag_a, flag_b} == exp_code(q.size()), tag, {flag_a, flag_b}, exp_code(q.size()));
    endtask

    task automatic put(input logic [W-1:0] d);
        @(negedge wr_clk); wr_en_n = 0; wr_data = d;
        @(negedge wr_clk); wr_en_n = 1;
        if (q.size() < DEPTH) q.push_back(d);
    endtask

    task automatic take(input string tag);
        logic [W-1:0] exp;
        @(negedge rd_clk); rd_en_n = 0;
        @(negedge rd_clk); rd_en_n = 1;
        if (q.size() > 0) begin exp = q.pop_front(); last_q = exp; end
        else exp = last_q;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    task automatic settle_wr; repeat (5) @(negedge wr_clk); endtask
    task automatic settle_rd; repeat (5) @(negedge rd_clk); endtask
    task automatic settle; settle_wr(); settle_rd(); endtask

    task automatic do_reset;
        rst_n = 0;
        repeat (3) @(negedge wr_clk);
        repeat (3) @(negedge rd_clk);
        rst_n = 1;
        q.delete(); last_q = '0;
        settle();
    endtask

    // R7: state right after power-on reset
    task automatic t_reset;
        do_reset();
        chk_code("R7 code after reset");
        chk(rd_data == 0, "R7 rd_data after reset", rd_data, 0);
    endtask

    // R1, R3: ordering with varied patterns including all-zero and all-one words
    task automatic t_order;
        put(9'h000); put(9'h1FF); put(9'h0AA); put(9'h155);
        for (int i = 0; i < 6; i++) put(W'((i * 37 + 5) & 9'h1FF));
        settle();
        for (int i = 0; i < 10; i++) take("R1 order");
    endtask

    // R3: read while empty keeps the previous word
    task automatic t_empty_read;
        settle();
        take("R3 hold on empty read");
        take("R3 hold on second empty read");
        chk_code("R3 still empty");
    endtask

    // R4, R6: every fill level from 0 to DEPTH and back down
    task automatic t_levels;
        for (int n = 1; n <= DEPTH; n++) begin
            put(W'(n * 11));
            settle();
            chk_code("R4 R6 fill band rising");
        end
        for (int n = 0; n < 6; n++) begin
            take("R1 drain");
            settle();
            chk_code("R4 R6 fill band falling");
        end
        while (q.size() > 0) take("R1 drain rest");
        settle();
        chk_code("R4 empty after drain");
    endtask

    // R2: writes while full are dropped
    task automatic t_overflow;
        for (int n = 0; n < DEPTH; n++) put(W'(300 + n));
        put(9'h1F0); put(9'h1F1); put(9'h1F2);
        settle();
        chk(q.size() == DEPTH, "R2 model full", q.size(), DEPTH);
        chk_code("R2 code when full");
        while (q.size() > 0) take("R2 contents after overflow attempts");
        take("R2 R3 read past last word holds");
        settle();
        chk_code("R2 empty after drain");
    endtask

    // R5: each flag follows only its own clock
    task automatic t_ownership;
        @(negedge rd_clk); rd_run = 0;
        put(9'h011); put(9'h022); put(9'h033);
        settle_wr();
        chk({flag_a, flag_b} == 2'b00, "R5 empty frozen while read clock stopped",
            {flag_a, flag_b}, 2'b00);
        rd_run = 1;
        settle_rd();
        chk_code("R5 R6 low band after read clock resumes");
        for (int n = 0; n < 10; n++) put(W'(64 + n));
        settle();
        chk_code("R5 high band");
        @(negedge wr_clk); wr_run = 0;
        for (int n = 0; n < 4; n++) take("R1 read with write clock stopped");
        settle_rd();
        chk({flag_a, flag_b} == 2'b10, "R5 high frozen while write clock stopped",
            {flag_a, flag_b}, 2'b10);
        wr_run = 1;
        settle();
        chk_code("R5 R6 middle band after write clock resumes");
        while (q.size() > 0) take("R1 drain after ownership");
        settle();
    endtask

    // R7: reset with data stored
    task automatic t_reset_mid;
        put(9'h101); put(9'h102); put(9'h103); put(9'h104); put(9'h105);
        settle();
        take("R1 before reset");
        do_reset();
        chk_code("R7 code after mid-stream reset");
        chk(rd_data == 0, "R7 rd_data after mid-stream reset", rd_data, 0);
        take("R7 no stale data after reset");
    endtask

    task automatic finish_up;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_order();
        t_empty_read();
        t_levels();
        t_overflow();
        t_ownership();
        t_reset_mid();
        finish_up();
    end

    initial begin
        #3_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end
endmodule